// File: doc/BRIEF.md
# Four-State Vector Comparator

This block compares two equal-width vectors whose bits each carry one of four states: 0, 1, unknown (x) or high impedance (z). It produces three condition results: logical equality, case equality and less-than. Each result is itself a four-state code. A mode input selects one of four behaviours. Two modes do ordered compares, one unsigned and one two's complement. The other two are wildcard equality tests that treat z, or both x and z, as matching anything.

Either operand may come from a packed vector input or from a single constant code, which is then copied to every bit position. The active width is chosen per operation, up to a parameter maximum. Positions at or above the width take no part in the compare. The whole vector is evaluated in parallel, and the results are registered, so they appear on the cycle after the start pulse. They hold until the next operation.

Top module: `vcmp_top`

## Requirements
- R1: Each bit position and each result flag is a 2-bit code: 0 means logic 0, 1 means logic 1, 2 means x, 3 means z. The mode codes are 0 for unsigned, 1 for signed, 2 for z-wildcard and 3 for xz-wildcard. Bit position i of an operand occupies bits [2i+1:2i] of its vector.
- R2: In modes 0 and 1, eeq is 1 when every active position holds the identical code in both operands, and 0 otherwise.
- R3: In modes 0 and 1, eq is 0 if any active position has known but different values on the two sides. Otherwise it is 2 if any active position holds x or z on either side, and 1 if not.
- R4: In mode 0, lt is 2 if any active position holds x or z on either side. Otherwise it is 1 exactly when the left operand is less than the right as an unsigned number.
- R5: In mode 1, lt follows R4 except that both operands are read as two's complement, with bit width-1 as the sign.
- R6: In mode 2, eq is 1 when every active position either holds z on at least one side or holds the identical code on both sides, and 0 otherwise.
- R7: In mode 3, eq is 1 when every active position either holds x or z on at least one side or holds the identical code on both sides, and 0 otherwise.
- R8: Modes 2 and 3 update only eq; lt and eeq keep their previous values.
- R9: When an operand's constant-select input is 1, its constant code is used at every bit position and its vector input is ignored.
- R10: A width of 0 in modes 0 and 1 gives eq=1, lt=0 and eeq=1.
- R11: Positions at or above the width have no effect on any result.
- R12: The results and done appear on the first clock edge after start is sampled high. Done is high for exactly that one cycle, and the results hold until the next start.
- R13: While reset is active, done, eq, lt and eeq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one compare in this cycle |
| mode_i | input | 2 | Compare mode (R1 codes) |
| width_i | input | $clog2(MAX_W+1) | Number of active bit positions |
| a_const_i | input | 1 | Left operand taken from a_code_i |
| a_code_i | input | 2 | Left constant code |
| a_vec_i | input | 2*MAX_W | Left operand, two bits per position |
| b_const_i | input | 1 | Right operand taken from b_code_i |
| b_code_i | input | 2 | Right constant code |
| b_vec_i | input | 2*MAX_W | Right operand, two bits per position |
| done_o | output | 1 | One-cycle strobe marking new results |
| eq_o | output | 2 | Logical or wildcard equality code |
| lt_o | output | 2 | Less-than code |
| eeq_o | output | 2 | Case equality code |

## Verification
All results are due one clock edge after the cycle in which start is high. There is a single register between the operand inputs and the flags. The bench drives inputs and start on a falling edge and drops start on the next falling edge. It then reads done and all three flags there, half a period after the capturing edge. A further idle cycle is read the same way, to confirm that done has fallen while the flags stay the same. After a wildcard operation, the bench expects lt and eeq to be whatever the previous ordered compare left in them.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
   typedef logic [1:0] fs_t;
   localparam fs_t FS_0 = 2'd0;
   localparam fs_t FS_1 = 2'd1;
   localparam fs_t FS_X = 2'd2;
   localparam fs_t FS_Z = 2'd3;

   typedef enum logic [1:0] {
      MODE_UNS = 2'd0,
      MODE_SGN = 2'd1,
      MODE_WZ  = 2'd2,
      MODE_WX  = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/vcmp_operand.sv
module vcmp_operand #(
   parameter int MAX_W = 32
) (
   input  logic [2*MAX_W-1:0] vec_i,
   input  logic               use_const_i,
   input  logic [1:0]         const_i,
   output logic [2*MAX_W-1:0] lanes_o
);
   for (genvar i = 0; i < MAX_W; i++) begin : g_rep
      assign lanes_o[2*i +: 2] = use_const_i ? const_i : vec_i[2*i +: 2];
   end
endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes #(
   parameter int MAX_W = 32,
   localparam int WW = $clog2(MAX_W + 1)
) (
   input  logic [2*MAX_W-1:0] a_i,
   input  logic [2*MAX_W-1:0] b_i,
   input  logic [WW-1:0]      eff_w_i,
   output logic [MAX_W-1:0]   diff_o,
   output logic [MAX_W-1:0]   kmis_o,
   output logic [MAX_W-1:0]   unk_o,
   output logic [MAX_W-1:0]   zmis_o,
   output logic [MAX_W-1:0]   xmis_o,
   output logic [MAX_W-1:0]   aval_o,
   output logic [MAX_W-1:0]   bval_o
);
   import vcmp_pkg::*;

   for (genvar i = 0; i < MAX_W; i++) begin : g_lane
      fs_t  ca, cb;
      logic act, same, a_unk, b_unk, zdc;
      assign ca    = a_i[2*i +: 2];
      assign cb    = b_i[2*i +: 2];
      assign act   = WW'(i) < eff_w_i;
      assign same  = (ca == cb);
      assign a_unk = ca[1];
      assign b_unk = cb[1];
      assign zdc   = (ca == FS_Z) || (cb == FS_Z);

      assign diff_o[i] = act && !same;
      assign kmis_o[i] = act && !a_unk && !b_unk && (ca[0] != cb[0]);
      assign unk_o[i]  = act && (a_unk || b_unk);
      assign zmis_o[i] = act && !zdc && !same;
      assign xmis_o[i] = act && !a_unk && !b_unk && !same;
      assign aval_o[i] = act && ca[0];
      assign bval_o[i] = act && cb[0];
   end
endmodule

// File: rtl/vcmp_order.sv
module vcmp_order #(
   parameter int MAX_W = 32,
   localparam int WW = $clog2(MAX_W + 1)
) (
   input  logic [MAX_W-1:0] aval_i,
   input  logic [MAX_W-1:0] bval_i,
   input  logic [WW-1:0]    eff_w_i,
   input  logic             signed_i,
   output logic             lt_o
);
   logic [MAX_W-1:0] smask;
   logic [MAX_W-1:0] a_adj, b_adj;

   for (genvar i = 0; i < MAX_W; i++) begin : g_sign
      assign smask[i] = signed_i && (eff_w_i == WW'(i + 1));
   end

   // flipping the sign bit maps two's complement order onto unsigned order
   assign a_adj = aval_i ^ smask;
   assign b_adj = bval_i ^ smask;
   assign lt_o  = a_adj < b_adj;
endmodule

// File: rtl/vcmp_top.sv
module vcmp_top #(
   parameter int MAX_W = 32,
   localparam int WW = $clog2(MAX_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         mode_i,
   input  logic [WW-1:0]      width_i,
   input  logic               a_const_i,
   input  logic [1:0]         a_code_i,
   input  logic [2*MAX_W-1:0] a_vec_i,
   input  logic               b_const_i,
   input  logic [1:0]         b_code_i,
   input  logic [2*MAX_W-1:0] b_vec_i,
   output logic               done_o,
   output logic [1:0]         eq_o,
   output logic [1:0]         lt_o,
   output logic [1:0]         eeq_o
);
   import vcmp_pkg::*;

   if (MAX_W < 1) begin : g_bad_width
      $error("vcmp_top: MAX_W must be at least 1");
   end

   cmp_mode_e        mode;
   logic [WW-1:0]    eff_w;
   logic [2*MAX_W-1:0] a_l, b_l;
   logic [MAX_W-1:0] diff, kmis, unk, zmis, xmis, aval, bval;
   logic             lt_bit;
   fs_t              arith_eq, arith_lt, arith_eeq, wild_eq;

   assign mode  = cmp_mode_e'(mode_i);
   assign eff_w = (width_i > WW'(MAX_W)) ? WW'(MAX_W) : width_i;

   vcmp_operand #(.MAX_W(MAX_W)) u_opa (
      .vec_i(a_vec_i), .use_const_i(a_const_i), .const_i(a_code_i), .lanes_o(a_l));
   vcmp_operand #(.MAX_W(MAX_W)) u_opb (
      .vec_i(b_vec_i), .use_const_i(b_const_i), .const_i(b_code_i), .lanes_o(b_l));

   vcmp_lanes #(.MAX_W(MAX_W)) u_lanes (
      .a_i(a_l), .b_i(b_l), .eff_w_i(eff_w),
      .diff_o(diff), .kmis_o(kmis), .unk_o(unk), .zmis_o(zmis), .xmis_o(xmis),
      .aval_o(aval), .bval_o(bval));

   vcmp_order #(.MAX_W(MAX_W)) u_order (
      .aval_i(aval), .bval_i(bval), .eff_w_i(eff_w),
      .signed_i(mode == MODE_SGN), .lt_o(lt_bit));

   assign arith_eq  = (|kmis) ? FS_0 : ((|unk) ? FS_X : FS_1);
   assign arith_lt  = (|unk) ? FS_X : (lt_bit ? FS_1 : FS_0);
   assign arith_eeq = (|diff) ? FS_0 : FS_1;
   assign wild_eq   = ((mode == MODE_WX) ? (|xmis) : (|zmis)) ? FS_0 : FS_1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         eq_o   <= FS_0;
         lt_o   <= FS_0;
         eeq_o  <= FS_0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            if (mode_i[1]) begin
               eq_o <= wild_eq;
            end else begin
               eq_o  <= arith_eq;
               lt_o  <= arith_lt;
               eeq_o <= arith_eeq;
            end
         end
      end
   end

   assert_width_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (width_i <= WW'(MAX_W)));
   assert_done_follows_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(eq_o) && $stable(lt_o) && $stable(eeq_o)));
   assert_wild_keeps_lt_eeq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && mode_i[1]) |=> ($stable(lt_o) && $stable(eeq_o)));
   assert_wild_eq_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && mode_i[1]) |=> (eq_o[1] == 1'b0));
   assert_eeq_not_neq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !mode_i[1]) |=> ((eeq_o == FS_1) -> (eq_o != FS_0)));
   assert_flag_no_z_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (eq_o != FS_Z) && (lt_o != FS_Z) && (eeq_o != FS_Z));
endmodule

// File: tb/sim_vcmp_top.sv
`timescale 1ns/1ps
module sim_vcmp_top;
   localparam int MW = 8;
   localparam int WW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [WW-1:0] width = '0;
   logic ac = 1'b0, bc = 1'b0;
   logic [1:0] acode = 2'd0, bcode = 2'd0;
   logic [2*MW-1:0] av = '0, bv = '0;
   logic done;
   logic [1:0] eq, lt, eeq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   vcmp_top #(.MAX_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .width_i(width),
      .a_const_i(ac), .a_code_i(acode), .a_vec_i(av),
      .b_const_i(bc), .b_code_i(bcode), .b_vec_i(bv),
      .done_o(done), .eq_o(eq), .lt_o(lt), .eeq_o(eeq));

   // row: {mode, width, a, b, eq, lt, eeq}; lt/eeq code 3 = expect previous value
   // operand bits use the R1 encoding, two bits per position, MSB position first
   localparam int NROW = 14;
   localparam logic [43:0] TAB [NROW] = '{
      {2'd0, 4'd8, 16'h0005, 16'h0011, 2'd0, 2'd1, 2'd0},
      {2'd0, 4'd8, 16'h4411, 16'h4411, 2'd1, 2'd0, 2'd1},
      {2'd0, 4'd8, 16'h5500, 16'h0055, 2'd0, 2'd0, 2'd0},
      {2'd1, 4'd8, 16'h5500, 16'h0055, 2'd0, 2'd1, 2'd0},
      {2'd1, 4'd4, 16'h0040, 16'h0015, 2'd0, 2'd1, 2'd0},
      {2'd0, 4'd4, 16'h0040, 16'h0015, 2'd0, 2'd0, 2'd0},
      {2'd0, 4'd8, 16'h0009, 16'h0005, 2'd2, 2'd2, 2'd0},
      {2'd0, 4'd8, 16'h0019, 16'h0005, 2'd0, 2'd2, 2'd0},
      {2'd0, 4'd8, 16'h3080, 16'h3080, 2'd2, 2'd2, 2'd1},
      {2'd2, 4'd8, 16'h00C5, 16'h0045, 2'd1, 2'd3, 2'd3},
      {2'd2, 4'd8, 16'h0085, 16'h0045, 2'd0, 2'd3, 2'd3},
      {2'd3, 4'd8, 16'h0085, 16'h0045, 2'd1, 2'd3, 2'd3},
      {2'd3, 4'd8, 16'h0085, 16'h0015, 2'd0, 2'd3, 2'd3},
      {2'd2, 4'd8, 16'h0080, 16'h0080, 2'd1, 2'd3, 2'd3}
   };

   logic [1:0] last_lt = 2'd0, last_eeq = 2'd0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] m, input logic [WW-1:0] w,
                      input logic a_c, input logic [1:0] a_k, input logic [2*MW-1:0] a_v,
                      input logic b_c, input logic [1:0] b_k, input logic [2*MW-1:0] b_v);
      @(negedge clk);
      mode = m; width = w; ac = a_c; acode = a_k; av = a_v;
      bc = b_c; bcode = b_k; bv = b_v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic expect3(input string teq, input string tlt, input string teeq,
                          input logic [1:0] e_eq, input logic [1:0] e_lt, input logic [1:0] e_eeq);
      chk("R12 done", int'(done), 1);
      chk(teq, int'(eq), int'(e_eq));
      chk(tlt, int'(lt), int'(e_lt));
      chk(teeq, int'(eeq), int'(e_eeq));
      last_lt = e_lt; last_eeq = e_eeq;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset values
      chk("R13 done", int'(done), 0);
      chk("R13 eq", int'(eq), 0);
      chk("R13 lt", int'(lt), 0);
      chk("R13 eeq", int'(eeq), 0);
      rst_n = 1'b1;

      for (int r = 0; r < NROW; r++) begin
         logic [1:0] m, e_lt, e_eeq;
         m = TAB[r][43:42];
         run(m, TAB[r][41:38], 1'b0, 2'd0, TAB[r][37:22], 1'b0, 2'd0, TAB[r][21:6]);
         e_lt  = (TAB[r][3:2] == 2'd3) ? last_lt  : TAB[r][3:2];
         e_eeq = (TAB[r][1:0] == 2'd3) ? last_eeq : TAB[r][1:0];
         expect3(m[1] ? ((m == 2'd2) ? "R1/R6 eq" : "R1/R7 eq") : "R1/R3 eq",
                 m[1] ? "R8 lt" : ((m == 2'd1) ? "R5 lt" : "R4 lt"),
                 m[1] ? "R8 eeq" : "R2 eeq",
                 TAB[r][5:4], e_lt, e_eeq);
      end

      // R11: upper positions differ, only low four active
      run(2'd0, 4'd4, 1'b0, 2'd0, 16'h5505, 1'b0, 2'd0, 16'h0005);
      expect3("R11 eq", "R11 lt", "R11 eeq", 2'd1, 2'd0, 2'd1);
      // R10: zero width
      run(2'd0, 4'd0, 1'b0, 2'd0, 16'h0055, 1'b0, 2'd0, 16'h0000);
      expect3("R10 eq", "R10 lt", "R10 eeq", 2'd1, 2'd0, 2'd1);
      // R9: constant 1 against all ones; vector input of a ignored
      run(2'd0, 4'd8, 1'b1, 2'd1, 16'h0000, 1'b0, 2'd0, 16'h5555);
      expect3("R9 eq", "R9 lt", "R9 eeq", 2'd1, 2'd0, 2'd1);
      // R9: constant x
      run(2'd0, 4'd8, 1'b1, 2'd2, 16'h5555, 1'b0, 2'd0, 16'h5555);
      expect3("R9 eq x", "R9 lt x", "R9 eeq x", 2'd2, 2'd2, 2'd0);
      // R9/R5: constant 0 vs constant 1 (= -1 signed)
      run(2'd1, 4'd8, 1'b1, 2'd0, 16'h0000, 1'b1, 2'd1, 16'h0000);
      expect3("R9 eq s", "R5 lt const", "R9 eeq s", 2'd0, 2'd0, 2'd0);
      run(2'd0, 4'd8, 1'b1, 2'd0, 16'h0000, 1'b1, 2'd1, 16'h0000);
      expect3("R9 eq u", "R4 lt const", "R9 eeq u", 2'd0, 2'd1, 2'd0);
      // R9/R6: constant z matches anything in z-wildcard mode
      run(2'd2, 4'd8, 1'b1, 2'd3, 16'h0000, 1'b0, 2'd0, 16'h4411);
      expect3("R9 eq wz", "R8 lt", "R8 eeq", 2'd1, last_lt, last_eeq);
      // R12: idle cycle, done drops and flags hold
      @(negedge clk);
      chk("R12 done low", int'(done), 0);
      chk("R12 eq hold", int'(eq), 1);
      chk("R12 lt hold", int'(lt), int'(last_lt));
      chk("R12 eeq hold", int'(eeq), int'(last_eeq));

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule